// File: doc/BRIEF.md
# Configuration Pin and Supply Fault Supervisor

This block decides whether a synchronous-rectifier controller may drive its gates. It takes digital flags from external comparators: three on the configuration pin (voltage below a short limit, voltage above an open limit, voltage above the frequency-mode threshold), two on the supply (at or above the turn-on level, below the turn-off level), one for supply overvoltage, and two for die temperature (too hot, recovered). It produces one global enable, the selected frequency mode and four fault status bits.

A single state machine owns the enable. Its states are `ST_OFF` (supply not valid), `ST_RUN` (enabled), `ST_OVP` (overvoltage, self-clearing), `ST_HOT` (over-temperature, waits for the recovered flag) and `ST_LOCK` (configuration pin open or shorted, held until the supply drops). The transitions are: power-good (`ST_OFF`→`ST_RUN`, which also samples the mode), brown-out (any state→`ST_OFF`), pin-lock (`ST_RUN`/`ST_OVP`/`ST_HOT`→`ST_LOCK`), overheat (`ST_RUN`/`ST_OVP`→`ST_HOT`), cool-down (`ST_HOT`→`ST_RUN`), overvoltage (`ST_RUN`→`ST_OVP`) and ov-clear (`ST_OVP`→`ST_RUN`). Each of the four fault flags passes through its own consecutive-sample debounce timer before the machine sees it. The defaults (100, 100, 3000 and 50 cycles) give about 2 µs for the pin faults and 60 µs for overvoltage at a 50 MHz clock.

Top module: `sup_supervisor`

## Requirements
- R1: While `rst_n` is low, `enable`, `freq_hf` and all four fault outputs are 0.
- R2: A clock edge that samples `vdd_off`=1 makes `enable` and all fault outputs 0 after that edge, whatever the other inputs are. An edge in `ST_OFF` that samples `vdd_on`=1 and `vdd_off`=0 sets `enable` to 1. While both supply flags are 0, the state is held, which gives the undervoltage hysteresis.
- R3: `freq_hf` takes the value of `pin_hf` sampled on the power-good edge and does not change until the next power-good edge.
- R4: When `pin_short` is sampled high on `PIN_DB_CYC` consecutive edges, the next edge clears `enable` and sets `flt_short`. Both stay in that state until `vdd_off` is sampled.
- R5: When `pin_open` is sampled high on `PIN_DB_CYC` consecutive edges, the next edge clears `enable` and sets `flt_open`. Both stay in that state until `vdd_off` is sampled.
- R6: When `vdd_ov` is sampled high on `OV_DB_CYC` consecutive edges, the next edge clears `enable` and sets `flt_ovp`. Once `vdd_ov` is sampled low, `enable` returns to 1 and `flt_ovp` to 0 two edges later.
- R7: When `temp_hot` is sampled high on `OT_DB_CYC` consecutive edges, the next edge clears `enable` and sets `flt_hot`. Both stay in that state until an edge samples `temp_ok`=1 with the temperature timer idle.
- R8: A fault flag that falls before its count is reached has no effect and restarts its timer, so shorter pulses do not add up.
- R9: The priority order is brown-out, then pin faults (short before open), then over-temperature, then overvoltage. In `ST_HOT` a qualified overvoltage is ignored. A qualified pin fault leaves `ST_OVP` or `ST_HOT` for `ST_LOCK`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_short | input | 1 | Config pin below the short limit |
| pin_open | input | 1 | Config pin above the open limit |
| pin_hf | input | 1 | Config pin above the frequency-mode threshold |
| vdd_on | input | 1 | Supply at or above the turn-on level |
| vdd_off | input | 1 | Supply below the turn-off level |
| vdd_ov | input | 1 | Supply overvoltage |
| temp_hot | input | 1 | Die over-temperature |
| temp_ok | input | 1 | Die temperature recovered |
| enable | output | 1 | Global gate-drive enable |
| freq_hf | output | 1 | Latched frequency mode (1 = high) |
| flt_short | output | 1 | Config pin short lock |
| flt_open | output | 1 | Config pin open lock |
| flt_ovp | output | 1 | Overvoltage active |
| flt_hot | output | 1 | Over-temperature active |

## Verification
For each fault flag, the bench sweeps the pulse length across the debounce limit, from one sample to two samples past it. A timer that is off by one would trip one length early or one length late. A timer that fails to restart when the flag falls would let short pulses add up and trip the fault. For each fault the bench then checks how it recovers. A pin lock that clears early, an overvoltage that latches, or a heat fault that clears without the recovered flag each shows up as a wrong enable. Further cases cover the priority order when flags arrive together, the frequency mode changing while the block runs, and the supply sitting between its two thresholds.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_RUN  = 3'd1,
        ST_OVP  = 3'd2,
        ST_HOT  = 3'd3,
        ST_LOCK = 3'd4
    } sup_state_e;

    localparam int unsigned N_FLT = 4;
    localparam int unsigned F_SHORT = 0;
    localparam int unsigned F_OPEN  = 1;
    localparam int unsigned F_OV    = 2;
    localparam int unsigned F_HOT   = 3;

endpackage

// File: rtl/sup_debounce.sv
module sup_debounce #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic qual
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!raw) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = (cnt == TOP);
endmodule

// File: rtl/sup_mode_latch.sv
module sup_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic pin_hf,
    output logic hf
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hf <= 1'b0;
        end else if (sample) begin
            hf <= pin_hf;
        end
    end
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import sup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vdd_on,
    input  logic             vdd_off,
    input  logic             temp_ok,
    input  logic [N_FLT-1:0] qual,
    output logic             power_good,
    output logic             enable,
    output logic             flt_short,
    output logic             flt_open,
    output logic             flt_ovp,
    output logic             flt_hot
);
    sup_state_e state, state_nx;
    logic       lock_short, lock_open;
    logic       pin_q;

    assign pin_q = qual[F_SHORT] | qual[F_OPEN];

    always_comb begin
        state_nx = state;
        if (vdd_off) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  if (vdd_on) state_nx = ST_RUN;
                ST_RUN: begin
                    if (pin_q)             state_nx = ST_LOCK;
                    else if (qual[F_HOT])  state_nx = ST_HOT;
                    else if (qual[F_OV])   state_nx = ST_OVP;
                end
                ST_OVP: begin
                    if (pin_q)             state_nx = ST_LOCK;
                    else if (qual[F_HOT])  state_nx = ST_HOT;
                    else if (!qual[F_OV])  state_nx = ST_RUN;
                end
                ST_HOT: begin
                    if (pin_q)                          state_nx = ST_LOCK;
                    else if (temp_ok && !qual[F_HOT])   state_nx = ST_RUN;
                end
                ST_LOCK: state_nx = ST_LOCK;
                default: state_nx = ST_OFF;
            endcase
        end
    end

    assign power_good = (state == ST_OFF) && (state_nx == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            lock_short <= 1'b0;
            lock_open  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_OFF) begin
                lock_short <= 1'b0;
                lock_open  <= 1'b0;
            end else if (state != ST_LOCK && state_nx == ST_LOCK) begin
                lock_short <= qual[F_SHORT];
                lock_open  <= !qual[F_SHORT];
            end
        end
    end

    always_comb begin
        enable    = 1'b0;
        flt_short = 1'b0;
        flt_open  = 1'b0;
        flt_ovp   = 1'b0;
        flt_hot   = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_RUN:  enable  = 1'b1;
            ST_OVP:  flt_ovp = 1'b1;
            ST_HOT:  flt_hot = 1'b1;
            ST_LOCK: begin
                flt_short = lock_short;
                flt_open  = lock_open;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sup_supervisor.sv
module sup_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned PIN_DB_CYC = 100,
    parameter int unsigned OV_DB_CYC  = 3000,
    parameter int unsigned OT_DB_CYC  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_short,
    input  logic pin_open,
    input  logic pin_hf,
    input  logic vdd_on,
    input  logic vdd_off,
    input  logic vdd_ov,
    input  logic temp_hot,
    input  logic temp_ok,
    output logic enable,
    output logic freq_hf,
    output logic flt_short,
    output logic flt_open,
    output logic flt_ovp,
    output logic flt_hot
);
    logic [N_FLT-1:0] raw;
    logic [N_FLT-1:0] qual;
    logic             power_good;

    assign raw[F_SHORT] = pin_short;
    assign raw[F_OPEN]  = pin_open;
    assign raw[F_OV]    = vdd_ov;
    assign raw[F_HOT]   = temp_hot;

    for (genvar g = 0; g < N_FLT; g++) begin : g_db
        localparam int unsigned LIM = (g == F_OV)  ? OV_DB_CYC :
                                      (g == F_HOT) ? OT_DB_CYC : PIN_DB_CYC;
        sup_debounce #(.LIMIT(LIM)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw[g]),
            .qual  (qual[g])
        );
    end

    sup_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .vdd_on     (vdd_on),
        .vdd_off    (vdd_off),
        .temp_ok    (temp_ok),
        .qual       (qual),
        .power_good (power_good),
        .enable     (enable),
        .flt_short  (flt_short),
        .flt_open   (flt_open),
        .flt_ovp    (flt_ovp),
        .flt_hot    (flt_hot)
    );

    sup_mode_latch u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (power_good),
        .pin_hf (pin_hf),
        .hf     (freq_hf)
    );
endmodule

// File: rtl/sup_supervisor_chk.sv
module sup_supervisor_chk #(
    parameter int unsigned PIN_DB_CYC = 100,
    parameter int unsigned OV_DB_CYC  = 3000,
    parameter int unsigned OT_DB_CYC  = 50
) (
    input logic clk,
    input logic rst_n,
    input logic pin_short,
    input logic pin_open,
    input logic vdd_off,
    input logic vdd_ov,
    input logic temp_hot,
    input logic temp_ok,
    input logic enable,
    input logic freq_hf,
    input logic flt_short,
    input logic flt_open,
    input logic flt_ovp,
    input logic flt_hot
);
    int unsigned short_run, ov_run, hot_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_run <= 0;
            ov_run    <= 0;
            hot_run   <= 0;
        end else begin
            short_run <= !pin_short ? 0 : (short_run < PIN_DB_CYC ? short_run + 1 : short_run);
            ov_run    <= !vdd_ov    ? 0 : (ov_run    < OV_DB_CYC  ? ov_run + 1    : ov_run);
            hot_run   <= !temp_hot  ? 0 : (hot_run   < OT_DB_CYC  ? hot_run + 1   : hot_run);
        end
    end

    AST_BROWNOUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_off |=> !enable && !flt_short && !flt_open && !flt_ovp && !flt_hot); // R2

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> $stable(freq_hf)); // R3

    AST_SHORT_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_short) |-> $past(short_run) >= PIN_DB_CYC); // R4

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_short || flt_open) && !vdd_off |=> (flt_short || flt_open)); // R5

    AST_OV_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_ovp) |-> $past(ov_run) >= OV_DB_CYC); // R6

    AST_HOT_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_hot) |-> $past(hot_run) >= OT_DB_CYC); // R7

    AST_HOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flt_hot && !temp_ok && !vdd_off && !$past(pin_short) && !$past(pin_open)
        |=> flt_hot); // R7
endmodule

bind sup_supervisor sup_supervisor_chk #(
    .PIN_DB_CYC (PIN_DB_CYC),
    .OV_DB_CYC  (OV_DB_CYC),
    .OT_DB_CYC  (OT_DB_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_short (pin_short),
    .pin_open  (pin_open),
    .vdd_off   (vdd_off),
    .vdd_ov    (vdd_ov),
    .temp_hot  (temp_hot),
    .temp_ok   (temp_ok),
    .enable    (enable),
    .freq_hf   (freq_hf),
    .flt_short (flt_short),
    .flt_open  (flt_open),
    .flt_ovp   (flt_ovp),
    .flt_hot   (flt_hot)
);

// File: tb/test_sup_supervisor.sv
`timescale 1ns/1ps
module test_sup_supervisor;
    localparam int PIN = 4;
    localparam int OV  = 6;
    localparam int OT  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_short = 0, pin_open = 0, pin_hf = 0;
    logic vdd_on = 0, vdd_off = 0, vdd_ov = 0, temp_hot = 0, temp_ok = 0;
    logic enable, freq_hf, flt_short, flt_open, flt_ovp, flt_hot;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sup_supervisor #(.PIN_DB_CYC(PIN), .OV_DB_CYC(OV), .OT_DB_CYC(OT)) i_sup_supervisor (
        .clk(clk), .rst_n(rst_n), .pin_short(pin_short), .pin_open(pin_open),
        .pin_hf(pin_hf), .vdd_on(vdd_on), .vdd_off(vdd_off), .vdd_ov(vdd_ov),
        .temp_hot(temp_hot), .temp_ok(temp_ok), .enable(enable), .freq_hf(freq_hf),
        .flt_short(flt_short), .flt_open(flt_open), .flt_ovp(flt_ovp), .flt_hot(flt_hot)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {enable, flt_short, flt_open, flt_ovp, flt_hot};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {en,short,open,ovp,hot} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_mode(input string req, input logic exp);
        n_vec++;
        if (freq_hf !== exp) begin
            n_bad++;
            $display("FAIL %s: freq_hf actual %b expected %b", req, freq_hf, exp);
        end
    endtask

    task automatic power_up(input logic hf);
        pin_short = 0; pin_open = 0; vdd_ov = 0; temp_hot = 0; temp_ok = 0;
        pin_hf = hf;
        vdd_off = 1; cyc(1);
        vdd_off = 0; vdd_on = 1; cyc(1);
        vdd_on = 0;
    endtask

    task automatic set_flag(input int f, input logic v);
        case (f)
            0: pin_short = v;
            1: pin_open  = v;
            2: vdd_ov    = v;
            default: temp_hot = v;
        endcase
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cyc(2);
        chk("R1 reset", 5'b00000);
        chk_mode("R1 reset mode", 1'b0);
        rst_n = 1'b1;
        cyc(2);
        chk("R2 idle off", 5'b00000);

        // Sweep each fault flag across its debounce limit
        for (int f = 0; f < 4; f++) begin
            for (int len = 1; len <= ((f == 2) ? OV : (f == 3) ? OT : PIN) + 2; len++) begin
                int lim;
                logic trip;
                logic [4:0] flt_exp;
                lim  = (f == 2) ? OV : (f == 3) ? OT : PIN;
                trip = (len >= lim);
                power_up(1'b0);
                chk("R2 power-good", 5'b10000);
                set_flag(f, 1'b1);
                cyc(len);
                set_flag(f, 1'b0);
                cyc(1);
                flt_exp = 5'b0;
                if (trip) flt_exp[3-f] = 1'b1;
                else      flt_exp[4]   = 1'b1;
                case (f)
                    0: chk(trip ? "R4 short trip" : "R8 short ignored", flt_exp);
                    1: chk(trip ? "R5 open trip"  : "R8 open ignored",  flt_exp);
                    2: chk(trip ? "R6 ov trip"    : "R8 ov ignored",    flt_exp);
                    default: chk(trip ? "R7 hot trip" : "R8 hot ignored", flt_exp);
                endcase
                if (trip) begin
                    if (f < 2) begin
                        cyc(4);
                        chk(f == 0 ? "R4 short latched" : "R5 open latched", flt_exp);
                        vdd_off = 1; cyc(1); vdd_off = 0;
                        chk(f == 0 ? "R4 short cleared by brown-out" : "R5 open cleared by brown-out", 5'b00000);
                    end else if (f == 2) begin
                        cyc(2);
                        chk("R6 ov recovered", 5'b10000);
                    end else begin
                        cyc(4);
                        chk("R7 hot held", 5'b00001);
                        temp_ok = 1; cyc(1); temp_ok = 0;
                        chk("R7 hot cleared", 5'b10000);
                    end
                end
            end
        end

        // Split pulses do not accumulate
        power_up(1'b0);
        vdd_ov = 1; cyc(OV - 1); vdd_ov = 0; cyc(1);
        vdd_ov = 1; cyc(OV - 1); vdd_ov = 0; cyc(1);
        chk("R8 ov split pulses", 5'b10000);
        pin_short = 1; cyc(PIN - 1); pin_short = 0; cyc(1);
        pin_short = 1; cyc(PIN - 1); pin_short = 0; cyc(1);
        chk("R8 short split pulses", 5'b10000);

        // Supply hysteresis and brown-out priority
        cyc(5);
        chk("R2 between thresholds holds on", 5'b10000);
        vdd_off = 1; cyc(1);
        chk("R2 brown-out", 5'b00000);
        vdd_on = 1; cyc(2);
        chk("R2 off wins over on", 5'b00000);
        vdd_off = 0; vdd_on = 0; cyc(3);
        chk("R2 between thresholds holds off", 5'b00000);

        // Frequency mode sampling
        power_up(1'b1);
        chk_mode("R3 mode high sampled", 1'b1);
        pin_hf = 0; cyc(3);
        chk_mode("R3 mode held while running", 1'b1);
        vdd_ov = 1; cyc(OV + 1); vdd_ov = 0; cyc(3);
        chk("R6 recovered for mode test", 5'b10000);
        chk_mode("R3 mode held across ov", 1'b1);
        power_up(1'b0);
        chk_mode("R3 mode low resampled", 1'b0);

        // Priority cases
        power_up(1'b0);
        pin_short = 1; pin_open = 1; cyc(PIN); pin_short = 0; pin_open = 0; cyc(1);
        chk("R9 short over open", 5'b01000);

        power_up(1'b0);
        temp_hot = 1; vdd_ov = 1; cyc(OV + 2); temp_hot = 0; vdd_ov = 0; cyc(1);
        chk("R9 hot over ov", 5'b00001);
        temp_ok = 1; cyc(1); temp_ok = 0;
        chk("R9 hot exits to run", 5'b10000);

        power_up(1'b0);
        vdd_ov = 1; cyc(OV + 1);
        chk("R9 in ovp", 5'b00010);
        pin_open = 1; cyc(PIN); pin_open = 0; cyc(1);
        chk("R9 pin over ovp", 5'b00100);
        vdd_ov = 0; vdd_off = 1; cyc(1); vdd_off = 0;
        chk("R9 brown-out over lock", 5'b00000);

        power_up(1'b0);
        temp_hot = 1; cyc(OT + 1); temp_hot = 0;
        pin_short = 1; cyc(PIN); pin_short = 0; cyc(1);
        chk("R9 pin over hot", 5'b01000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule